// File: doc/BRIEF.md
# Cache Stall-Cause and Bus-Request Tracker

This block records the reasons a cache controller is holding off new work and the reasons it wants the memory-side bus. It keeps three cause masks. The access-path stall mask and the snoop-path stall mask each hold one bit per stall cause. The bus-request mask holds one bit per request cause. Set and clear strobes carry a cause code that selects the bit.

The block produces one-cycle block and unblock pulses for the CPU-side and memory-side ports. A pulse fires only when the matching stall mask moves between empty and non-empty. It also produces a one-cycle bus-request pulse when a request is new and no retry is pending.

Per stall cause, the block counts how many access-path stalls began with that cause. It also accumulates the cycles each stall lasted, charged to the cause whose clear ended the stall. A drain request completes once no bus request is outstanding and both ports report empty pending and transmit queues.

Top module: `cache_stall_tracker`

## Requirements
- R1: After reset all three masks are zero, every event and cycle counter is zero, no pulse output is high and no drain request is pending.
- R2: A stall set strobe with cause code c sets bit c of its mask: 0 is no free miss buffer, 1 is no free target slot, 2 is no free writeback buffer and 3 is a coherence stall. Setting a bit that is already set leaves the mask, the pulses and the counters unchanged.
- R3: All mask and pulse outputs change on the clock edge that samples the strobe. `cpu_block` is high for one cycle only when the access mask goes from zero to non-zero. `mem_block` does the same for the snoop mask.
- R4: When the access mask goes from zero to non-zero, the event counter of the cause being set increments by one, and the current cycle is stamped as the stall start. Setting only the snoop mask touches no counter.
- R5: A stall clear with cause c removes bit c from both the access mask and the snoop mask. `cpu_unblock` pulses when the access mask becomes zero, and `mem_unblock` pulses when the snoop mask becomes zero.
- R6: When the access mask becomes zero, the number of clock edges from the edge that started the stall to the edge that ended it is added to the cycle counter of the cause in that final clear. Clears that leave the mask non-zero add nothing.
- R7: A bus-request set with cause c sets bit c of the request mask: 0 is miss buffer, 1 is writeback, 2 is coherence and 3 is prefetch. It pulses `bus_req_pulse` for one cycle only if the request mask was zero and `retry_wait` was low in that cycle. The bit is set in either case.
- R8: A bus-request clear removes only its own bit. `bus_requested` is high while any request bit is set.
- R9: `drain_ready` is high exactly when the request mask is zero and all four queue-empty inputs are high. A drain request, once seen, stays pending. `drain_done` pulses on the edge after the first cycle in which it is pending and `drain_ready` is high, and the request then retires.
- R10: When a set strobe and a clear strobe name the same cause in the same cycle, the bit ends up set. This applies to both stall masks and to the request mask.
- R11: Event and cycle counters are CNT_W bits wide and saturate at all-ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_set_vld | input | 1 | Set a cause in the access stall mask |
| acc_set_cause | input | $clog2(N_CAUSE) | Stall cause code for acc_set_vld |
| snp_set_vld | input | 1 | Set a cause in the snoop stall mask |
| snp_set_cause | input | $clog2(N_CAUSE) | Stall cause code for snp_set_vld |
| stall_clr_vld | input | 1 | Clear a cause from both stall masks |
| stall_clr_cause | input | $clog2(N_CAUSE) | Stall cause code for stall_clr_vld |
| req_set_vld | input | 1 | Raise a bus-request cause |
| req_set_cause | input | $clog2(N_CAUSE) | Request cause code for req_set_vld |
| req_clr_vld | input | 1 | Drop a bus-request cause |
| req_clr_cause | input | $clog2(N_CAUSE) | Request cause code for req_clr_vld |
| retry_wait | input | 1 | A bus retry is pending; suppresses the request pulse |
| cpu_pend_empty | input | 1 | CPU-side pending queue is empty |
| cpu_xmit_empty | input | 1 | CPU-side transmit queue is empty |
| mem_pend_empty | input | 1 | Memory-side pending queue is empty |
| mem_xmit_empty | input | 1 | Memory-side transmit queue is empty |
| drain_req | input | 1 | Request a drain |
| acc_mask | output | N_CAUSE | Access stall mask |
| snp_mask | output | N_CAUSE | Snoop stall mask |
| req_mask | output | N_CAUSE | Bus-request mask |
| cpu_block | output | 1 | One-cycle block pulse to the CPU-side port |
| cpu_unblock | output | 1 | One-cycle unblock pulse to the CPU-side port |
| mem_block | output | 1 | One-cycle block pulse to the memory-side port |
| mem_unblock | output | 1 | One-cycle unblock pulse to the memory-side port |
| bus_req_pulse | output | 1 | One-cycle memory-side bus request |
| bus_requested | output | 1 | Any request cause outstanding |
| drain_ready | output | 1 | Drain condition holds now |
| drain_done | output | 1 | One-cycle pulse when a pending drain completes |
| stall_events | output | N_CAUSE*CNT_W | Per-cause stall start counts, cause c at bits [c*CNT_W +: CNT_W] |
| stall_cycles | output | N_CAUSE*CNT_W | Per-cause stalled cycle totals, same packing |

## Verification
Two functions can fall in the same cycle: a set and a clear on one stall mask, or on the request mask. The bench drives both strobes in a single cycle. It uses the same cause, which must leave the bit set. It also uses different causes, where one cause leaves the mask as another enters; the mask must then swap bits with no block, unblock or event count. Separately, a second cause is added during a stall and the first is removed. This checks that cycles are charged only to the cause whose clear empties the mask, counted edge by edge from the start of the stall.

// File: rtl/stall_tracker_pkg.sv
package stall_tracker_pkg;

   typedef enum logic [1:0] {
      STALL_NO_MISSBUF = 2'd0,
      STALL_NO_TARGET  = 2'd1,
      STALL_NO_WBBUF   = 2'd2,
      STALL_COHERENCE  = 2'd3
   } stall_cause_e;

   typedef enum logic [1:0] {
      BUSREQ_MISS      = 2'd0,
      BUSREQ_WRITEBACK = 2'd1,
      BUSREQ_COHERENCE = 2'd2,
      BUSREQ_PREFETCH  = 2'd3
   } busreq_cause_e;

   localparam int MIN_CAUSES = 4;

endpackage

// File: rtl/stall_mask_unit.sv
module stall_mask_unit #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_vld,
   input  logic [IW-1:0] set_idx,
   input  logic         clr_vld,
   input  logic [IW-1:0] clr_idx,
   output logic [N-1:0] mask_o,
   output logic         goes_busy_o,
   output logic         goes_idle_o,
   output logic         busy_pulse_o,
   output logic         idle_pulse_o
);
   logic [N-1:0] mask_q, mask_d, set_bits, clr_bits;

   always_comb begin
      set_bits = '0;
      clr_bits = '0;
      if (set_vld) set_bits[set_idx] = 1'b1;
      if (clr_vld) clr_bits[clr_idx] = 1'b1;
      mask_d = (mask_q & ~clr_bits) | set_bits;
   end

   assign goes_busy_o = (mask_q == '0) && (mask_d != '0);
   assign goes_idle_o = (mask_q != '0) && (mask_d == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q       <= '0;
         busy_pulse_o <= 1'b0;
         idle_pulse_o <= 1'b0;
      end else begin
         mask_q       <= mask_d;
         busy_pulse_o <= goes_busy_o;
         idle_pulse_o <= goes_idle_o;
      end
   end

   assign mask_o = mask_q;
endmodule

// File: rtl/stall_counters.sv
module stall_counters #(
   parameter int N     = 4,
   parameter int IW    = 2,
   parameter int CNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_evt,
   input  logic [IW-1:0]      start_idx,
   input  logic               stop_evt,
   input  logic [IW-1:0]      stop_idx,
   output logic [N*CNT_W-1:0] evt_cnt_o,
   output logic [N*CNT_W-1:0] cyc_cnt_o
);
   logic [CNT_W-1:0] now_q, start_q, span;

   assign span = now_q - start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q   <= '0;
         start_q <= '0;
      end else begin
         now_q <= now_q + 1'b1;
         if (start_evt) start_q <= now_q;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_cause
      logic [CNT_W-1:0] evt_q, cyc_q;
      logic [CNT_W:0]   evt_sum, cyc_sum;

      assign evt_sum = {1'b0, evt_q} + {{CNT_W{1'b0}}, 1'b1};
      assign cyc_sum = {1'b0, cyc_q} + {1'b0, span};

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            evt_q <= '0;
            cyc_q <= '0;
         end else begin
            if (start_evt && (start_idx == IW'(i)))
               evt_q <= evt_sum[CNT_W] ? '1 : evt_sum[CNT_W-1:0];
            if (stop_evt && (stop_idx == IW'(i)))
               cyc_q <= cyc_sum[CNT_W] ? '1 : cyc_sum[CNT_W-1:0];
         end
      end

      assign evt_cnt_o[i*CNT_W +: CNT_W] = evt_q;
      assign cyc_cnt_o[i*CNT_W +: CNT_W] = cyc_q;
   end
endmodule

// File: rtl/bus_req_unit.sv
module bus_req_unit #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_vld,
   input  logic [IW-1:0] set_idx,
   input  logic          clr_vld,
   input  logic [IW-1:0] clr_idx,
   input  logic          retry_wait,
   output logic [N-1:0]  mask_o,
   output logic          pulse_o,
   output logic          any_o
);
   logic [N-1:0] mask_q, set_bits, clr_bits;

   always_comb begin
      set_bits = '0;
      clr_bits = '0;
      if (set_vld) set_bits[set_idx] = 1'b1;
      if (clr_vld) clr_bits[clr_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q  <= '0;
         pulse_o <= 1'b0;
      end else begin
         mask_q  <= (mask_q & ~clr_bits) | set_bits;
         pulse_o <= set_vld && (mask_q == '0) && !retry_wait;
      end
   end

   assign mask_o = mask_q;
   assign any_o  = |mask_q;
endmodule

// File: rtl/drain_unit.sv
module drain_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic req_idle,
   input  logic cpu_pend_empty,
   input  logic cpu_xmit_empty,
   input  logic mem_pend_empty,
   input  logic mem_xmit_empty,
   input  logic drain_req,
   output logic ready_o,
   output logic done_o
);
   logic pend_q, pend_eff;

   assign ready_o  = req_idle && cpu_pend_empty && cpu_xmit_empty &&
                     mem_pend_empty && mem_xmit_empty;
   assign pend_eff = pend_q || drain_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= pend_eff && ready_o;
         pend_q <= pend_eff && !ready_o;
      end
   end
endmodule

// File: rtl/cache_stall_tracker.sv
module cache_stall_tracker
   import stall_tracker_pkg::*;
#(
   parameter int N_CAUSE = 4,
   parameter int CNT_W   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       acc_set_vld,
   input  logic [$clog2(N_CAUSE)-1:0] acc_set_cause,
   input  logic                       snp_set_vld,
   input  logic [$clog2(N_CAUSE)-1:0] snp_set_cause,
   input  logic                       stall_clr_vld,
   input  logic [$clog2(N_CAUSE)-1:0] stall_clr_cause,
   input  logic                       req_set_vld,
   input  logic [$clog2(N_CAUSE)-1:0] req_set_cause,
   input  logic                       req_clr_vld,
   input  logic [$clog2(N_CAUSE)-1:0] req_clr_cause,
   input  logic                       retry_wait,
   input  logic                       cpu_pend_empty,
   input  logic                       cpu_xmit_empty,
   input  logic                       mem_pend_empty,
   input  logic                       mem_xmit_empty,
   input  logic                       drain_req,
   output logic [N_CAUSE-1:0]         acc_mask,
   output logic [N_CAUSE-1:0]         snp_mask,
   output logic [N_CAUSE-1:0]         req_mask,
   output logic                       cpu_block,
   output logic                       cpu_unblock,
   output logic                       mem_block,
   output logic                       mem_unblock,
   output logic                       bus_req_pulse,
   output logic                       bus_requested,
   output logic                       drain_ready,
   output logic                       drain_done,
   output logic [N_CAUSE*CNT_W-1:0]   stall_events,
   output logic [N_CAUSE*CNT_W-1:0]   stall_cycles
);
   localparam int IW = $clog2(N_CAUSE);

   if (N_CAUSE < MIN_CAUSES || (1 << IW) != N_CAUSE) begin : g_bad_ncause
      $error("N_CAUSE must be a power of two no smaller than four");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("CNT_W must be at least two");
   end

   logic acc_busy, acc_idle, snp_busy_unused, snp_idle_unused;

   stall_mask_unit #(.N(N_CAUSE), .IW(IW)) u_acc (
      .clk(clk), .rst_n(rst_n),
      .set_vld(acc_set_vld), .set_idx(acc_set_cause),
      .clr_vld(stall_clr_vld), .clr_idx(stall_clr_cause),
      .mask_o(acc_mask), .goes_busy_o(acc_busy), .goes_idle_o(acc_idle),
      .busy_pulse_o(cpu_block), .idle_pulse_o(cpu_unblock));

   stall_mask_unit #(.N(N_CAUSE), .IW(IW)) u_snp (
      .clk(clk), .rst_n(rst_n),
      .set_vld(snp_set_vld), .set_idx(snp_set_cause),
      .clr_vld(stall_clr_vld), .clr_idx(stall_clr_cause),
      .mask_o(snp_mask), .goes_busy_o(snp_busy_unused), .goes_idle_o(snp_idle_unused),
      .busy_pulse_o(mem_block), .idle_pulse_o(mem_unblock));

   stall_counters #(.N(N_CAUSE), .IW(IW), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .start_evt(acc_busy), .start_idx(acc_set_cause),
      .stop_evt(acc_idle), .stop_idx(stall_clr_cause),
      .evt_cnt_o(stall_events), .cyc_cnt_o(stall_cycles));

   bus_req_unit #(.N(N_CAUSE), .IW(IW)) u_req (
      .clk(clk), .rst_n(rst_n),
      .set_vld(req_set_vld), .set_idx(req_set_cause),
      .clr_vld(req_clr_vld), .clr_idx(req_clr_cause),
      .retry_wait(retry_wait),
      .mask_o(req_mask), .pulse_o(bus_req_pulse), .any_o(bus_requested));

   drain_unit u_drain (
      .clk(clk), .rst_n(rst_n),
      .req_idle(req_mask == '0),
      .cpu_pend_empty(cpu_pend_empty), .cpu_xmit_empty(cpu_xmit_empty),
      .mem_pend_empty(mem_pend_empty), .mem_xmit_empty(mem_xmit_empty),
      .drain_req(drain_req),
      .ready_o(drain_ready), .done_o(drain_done));
endmodule

// File: rtl/cache_stall_tracker_chk.sv
module cache_stall_tracker_chk #(
   parameter int N_CAUSE = 4,
   parameter int CNT_W   = 32
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     retry_wait,
   input logic [N_CAUSE-1:0]       acc_mask,
   input logic [N_CAUSE-1:0]       snp_mask,
   input logic [N_CAUSE-1:0]       req_mask,
   input logic                     cpu_block,
   input logic                     cpu_unblock,
   input logic                     mem_block,
   input logic                     mem_unblock,
   input logic                     bus_req_pulse,
   input logic                     drain_ready,
   input logic                     drain_done,
   input logic [N_CAUSE*CNT_W-1:0] stall_events,
   input logic [N_CAUSE*CNT_W-1:0] stall_cycles
);
   AST_CPU_BLOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_block |-> (acc_mask != '0) && ($past(acc_mask) == '0)); // R3
   AST_MEM_BLOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_block |-> (snp_mask != '0) && ($past(snp_mask) == '0)); // R3
   AST_CPU_UNBLOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_unblock |-> (acc_mask == '0) && ($past(acc_mask) != '0)); // R5
   AST_MEM_UNBLOCK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_unblock |-> (snp_mask == '0) && ($past(snp_mask) != '0)); // R5
   AST_BUS_PULSE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_pulse |-> ($past(req_mask) == '0) && !$past(retry_wait) && (req_mask != '0)); // R7
   AST_DRAIN_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      drain_done |-> $past(drain_ready)); // R9

   for (genvar i = 0; i < N_CAUSE; i++) begin : g_mono
      AST_EVT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         stall_events[i*CNT_W +: CNT_W] >= $past(stall_events[i*CNT_W +: CNT_W])); // R11
      AST_CYC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         stall_cycles[i*CNT_W +: CNT_W] >= $past(stall_cycles[i*CNT_W +: CNT_W])); // R11
   end
endmodule

bind cache_stall_tracker cache_stall_tracker_chk #(.N_CAUSE(N_CAUSE), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .retry_wait(retry_wait),
   .acc_mask(acc_mask), .snp_mask(snp_mask), .req_mask(req_mask),
   .cpu_block(cpu_block), .cpu_unblock(cpu_unblock),
   .mem_block(mem_block), .mem_unblock(mem_unblock),
   .bus_req_pulse(bus_req_pulse), .drain_ready(drain_ready), .drain_done(drain_done),
   .stall_events(stall_events), .stall_cycles(stall_cycles));

// File: tb/cache_stall_tracker_test.sv
module cache_stall_tracker_test;
   localparam int NC = 4;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_set_vld = 0, snp_set_vld = 0, stall_clr_vld = 0;
   logic [1:0] acc_set_cause = 0, snp_set_cause = 0, stall_clr_cause = 0;
   logic req_set_vld = 0, req_clr_vld = 0, retry_wait = 0;
   logic [1:0] req_set_cause = 0, req_clr_cause = 0;
   logic cpu_pend_empty = 1, cpu_xmit_empty = 1, mem_pend_empty = 1, mem_xmit_empty = 1;
   logic drain_req = 0;
   logic [NC-1:0] acc_mask, snp_mask, req_mask;
   logic cpu_block, cpu_unblock, mem_block, mem_unblock;
   logic bus_req_pulse, bus_requested, drain_ready, drain_done;
   logic [NC*CW-1:0] stall_events, stall_cycles;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   cache_stall_tracker #(.N_CAUSE(NC), .CNT_W(CW)) uut (.*);

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint evt(int c); return stall_events[c*CW +: CW]; endfunction
   function automatic longint cyc(int c); return stall_cycles[c*CW +: CW]; endfunction

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      acc_set_vld = 0; snp_set_vld = 0; stall_clr_vld = 0;
      req_set_vld = 0; req_clr_vld = 0; drain_req = 0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      retry_wait = 0;
      cpu_pend_empty = 1; cpu_xmit_empty = 1; mem_pend_empty = 1; mem_xmit_empty = 1;
      tick(); tick();
      rst_n = 1;
   endtask

   task automatic acc_set(int c); acc_set_vld = 1; acc_set_cause = 2'(c); endtask
   task automatic snp_set(int c); snp_set_vld = 1; snp_set_cause = 2'(c); endtask
   task automatic clr(int c); stall_clr_vld = 1; stall_clr_cause = 2'(c); endtask

   task automatic t_reset();
      do_reset();
      check("R1 acc_mask", acc_mask, 0);
      check("R1 snp_mask", snp_mask, 0);
      check("R1 req_mask", req_mask, 0);
      check("R1 pulses", {cpu_block, cpu_unblock, mem_block, mem_unblock, bus_req_pulse, drain_done}, 0);
      check("R1 counters", stall_events | stall_cycles, 0);
      tick();
      check("R1 no pending drain", drain_done, 0);
   endtask

   task automatic t_access_stall();
      do_reset();
      acc_set(2); tick();
      check("R2 mask bit 2", acc_mask, 4'b0100);
      check("R3 cpu_block", cpu_block, 1);
      check("R4 evt[2]", evt(2), 1);
      acc_set(2); tick();
      check("R2 repeat set mask", acc_mask, 4'b0100);
      check("R2 repeat set no block", cpu_block, 0);
      check("R2 repeat set evt", evt(2), 1);
      tick(); tick(); tick();
      clr(2); tick();
      check("R5 cpu_unblock", cpu_unblock, 1);
      check("R5 acc_mask empty", acc_mask, 0);
      check("R6 cycles[2]", cyc(2), 5);
      tick();
      check("R3 unblock one cycle", cpu_unblock, 0);
   endtask

   task automatic t_release_billing();
      do_reset();
      acc_set(0); tick();
      tick(); tick();
      acc_set(1); tick();
      check("R3 second cause no block", cpu_block, 0);
      check("R4 second cause no event", evt(1), 0);
      clr(0); tick();
      check("R6 partial clear no unblock", cpu_unblock, 0);
      check("R6 partial clear mask", acc_mask, 4'b0010);
      check("R6 partial clear no bill", cyc(0), 0);
      clr(1); tick();
      check("R6 billed to releaser", cyc(1), 5);
      check("R6 unblock on release", cpu_unblock, 1);
      check("R4 evt[0]", evt(0), 1);
   endtask

   task automatic t_snoop();
      do_reset();
      snp_set(3); tick();
      check("R3 snp_mask", snp_mask, 4'b1000);
      check("R3 mem_block", mem_block, 1);
      check("R3 no cpu_block", cpu_block, 0);
      check("R4 snoop no event", evt(3), 0);
      acc_set(3); snp_set(1); tick();
      check("R3 cpu_block", cpu_block, 1);
      check("R3 mem no reblock", mem_block, 0);
      clr(3); tick();
      check("R5 acc cleared", acc_mask, 0);
      check("R5 cpu_unblock", cpu_unblock, 1);
      check("R5 snp partial", snp_mask, 4'b0010);
      check("R5 no mem_unblock", mem_unblock, 0);
      clr(1); tick();
      check("R5 mem_unblock", mem_unblock, 1);
      check("R5 snp empty", snp_mask, 0);
   endtask

   task automatic t_same_cycle();
      do_reset();
      acc_set(1); clr(1); tick();
      check("R10 set wins from empty", acc_mask, 4'b0010);
      check("R10 block pulse", cpu_block, 1);
      acc_set(1); clr(1); tick();
      check("R10 set wins when held", acc_mask, 4'b0010);
      check("R10 no unblock", cpu_unblock, 0);
      acc_set(0); clr(1); tick();
      check("R10 swap mask", acc_mask, 4'b0001);
      check("R10 swap no pulses", {cpu_block, cpu_unblock}, 0);
      check("R10 swap no event", evt(0), 0);
      snp_set(2); tick();
      snp_set(2); clr(2); tick();
      check("R10 snoop set wins", snp_mask, 4'b0100);
      req_set_vld = 1; req_set_cause = 2; req_clr_vld = 1; req_clr_cause = 2; tick();
      check("R10 request set wins", req_mask, 4'b0100);
   endtask

   task automatic t_bus();
      do_reset();
      retry_wait = 1;
      req_set_vld = 1; req_set_cause = 3; tick();
      check("R7 retry suppresses pulse", bus_req_pulse, 0);
      check("R7 bit set under retry", req_mask, 4'b1000);
      check("R8 requested", bus_requested, 1);
      retry_wait = 0;
      req_clr_vld = 1; req_clr_cause = 3; tick();
      check("R8 cleared", bus_requested, 0);
      req_set_vld = 1; req_set_cause = 1; tick();
      check("R7 new request pulse", bus_req_pulse, 1);
      check("R7 mask", req_mask, 4'b0010);
      req_set_vld = 1; req_set_cause = 0; tick();
      check("R7 outstanding no pulse", bus_req_pulse, 0);
      check("R7 two causes", req_mask, 4'b0011);
      req_clr_vld = 1; req_clr_cause = 1; tick();
      check("R8 own bit only", req_mask, 4'b0001);
      check("R8 still requested", bus_requested, 1);
   endtask

   task automatic t_drain();
      do_reset();
      req_set_vld = 1; req_set_cause = 0; tick();
      drain_req = 1; tick();
      check("R9 not ready with request", drain_ready, 0);
      check("R9 no done", drain_done, 0);
      cpu_xmit_empty = 0;
      req_clr_vld = 1; req_clr_cause = 0; tick();
      check("R9 not ready with busy queue", drain_ready, 0);
      tick();
      check("R9 pending waits", drain_done, 0);
      cpu_xmit_empty = 1; #1;
      check("R9 ready", drain_ready, 1);
      tick();
      check("R9 done pulse", drain_done, 1);
      tick();
      check("R9 done retires", drain_done, 0);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int i = 0; i < 260; i++) begin
         acc_set(0); tick();
         clr(0); tick();
      end
      check("R11 event saturates", evt(0), 255);
      for (int k = 0; k < 3; k++) begin
         acc_set(1); tick();
         repeat (99) tick();
         clr(1); tick();
      end
      check("R11 cycles saturate", cyc(1), 255);
   endtask

   initial begin
      t_reset();
      t_access_stall();
      t_release_billing();
      t_snoop();
      t_same_cycle();
      t_bus();
      t_drain();
      t_saturate();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule